// File: doc/BRIEF.md
# Paged Program Counter with Wrapping Return Stack

This block holds the instruction address of a small controller and decides each cycle where the next fetch comes from. The address is 13 bits wide, which covers 8192 words split into four pages of 2048 words. An external decoder supplies a 3-bit operation code, an 11-bit target offset, a branch condition and an interrupt vector. The block presents the registered program counter on `pc`.

Long jumps and calls do not take their page from the current address. They take it from a 2-bit page preselect register, which software loads beforehand through `page_we`/`page_sel`. Conditional branches ignore that register and always land in the page the program counter is already in.

Calls and interrupt entries save a return address in an 8-entry ring. A return takes the most recent entry back. Pushing a ninth entry silently replaces the oldest one. Popping more entries than were pushed never faults: it keeps walking around the ring.

Top module: `pc_stack_unit`

## Requirements
- R1: While `rst_n` is low, `pc` is 0. After reset the page register is 0 and all eight stack slots hold 0.
- R2: Op 3'b000 (advance) loads `pc + 1` on the next edge, and 13'h1FFF advances to 13'h0000.
- R3: Op 3'b001 (jump) loads `{page, offset}`, with the page register forming bits 12:11 and `offset` forming bits 10:0.
- R4: When `page_we` is high, the page register takes `page_sel` at the edge. A jump or call in that same cycle still uses the previous page value.
- R5: Op 3'b010 (call) pushes `pc + 1` and then loads `{page, offset}`.
- R6: Op 3'b011 (branch) loads `{pc[12:11], offset}` when `cond` is 1 and `pc + 1` when `cond` is 0. The page register has no effect on a branch.
- R7: Op 3'b100 (interrupt entry) pushes the current `pc` unchanged and loads `vector`.
- R8: Op 3'b101 (return) loads the most recently pushed entry that has not been popped, and removes that entry from the stack.
- R9: After more than eight pushes, the stack holds only the eight most recent entries. The oldest entry is overwritten with no indication.
- R10: A return with no remaining pushed entries reads the slot below the ring position. That slot holds either an older overwritten value or the reset value 0. It raises no error and leaves no blocked state.
- R11: Op codes 3'b110 and 3'b111 leave `pc` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Flow operation code |
| offset | input | 11 | Target offset within a page |
| cond | input | 1 | Branch taken when high |
| vector | input | 13 | Interrupt entry address |
| page_we | input | 1 | Page register write strobe |
| page_sel | input | 2 | Page register write data |
| pc | output | 13 | Current program counter |

## Verification
The hardest situation to reach is the stack after more than eight pushes. In that state the oldest return addresses have been overwritten, and later pops run past the logical bottom and around the ring. A directed burst of ten nested calls with distinct offsets, followed by twelve returns, drives the block into this state on purpose. A long random op stream then keeps the stack depth drifting far above and below eight. The reference model keeps the stack as a rotating queue, so every over-pop value is predicted independently of the ring pointer.

// File: rtl/pc_stack_unit.sv
module pc_stack_unit #(
  parameter int PC_W  = 13,
  parameter int PG_W  = 2,
  parameter int DEPTH = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2:0]           op,
  input  logic [PC_W-PG_W-1:0] offset,
  input  logic                 cond,
  input  logic [PC_W-1:0]      vector,
  input  logic                 page_we,
  input  logic [PG_W-1:0]      page_sel,
  output logic [PC_W-1:0]      pc
);
  localparam int SP_W = $clog2(DEPTH);
  localparam logic [2:0] OP_NEXT = 3'd0, OP_JUMP = 3'd1, OP_CALL = 3'd2,
                         OP_BR   = 3'd3, OP_INT  = 3'd4, OP_RET  = 3'd5;

  logic [PC_W-1:0] pc_q, pc_d, push_val;
  logic [PG_W-1:0] page_q;
  logic [SP_W-1:0] sp;
  logic [PC_W-1:0] ring [DEPTH];
  logic            push, pop;

  wire [PC_W-1:0] pc_inc  = pc_q + 1'b1;
  wire [PC_W-1:0] far_tgt = {page_q, offset};
  wire [PC_W-1:0] br_tgt  = {pc_q[PC_W-1 -: PG_W], offset};
  wire [SP_W-1:0] sp_dn   = sp - 1'b1;

  assign push     = (op == OP_CALL) || (op == OP_INT);
  assign pop      = (op == OP_RET);
  assign push_val = (op == OP_CALL) ? pc_inc : pc_q;
  assign pc       = pc_q;

  always_comb begin
    case (op)
      OP_NEXT: pc_d = pc_inc;
      OP_JUMP,
      OP_CALL: pc_d = far_tgt;
      OP_BR:   pc_d = cond ? br_tgt : pc_inc;
      OP_INT:  pc_d = vector;
      OP_RET:  pc_d = ring[sp_dn];
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q   <= '0;
      page_q <= '0;
      sp     <= '0;
    end else begin
      pc_q <= pc_d;
      if (page_we) page_q <= page_sel;
      if (push)     sp <= sp + 1'b1;
      else if (pop) sp <= sp_dn;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ring[i] <= '0;
      else if (push && sp == SP_W'(i))  ring[i] <= push_val;
    end
  end

  assert_reset_R1: assert property (@(posedge clk) !rst_n |-> pc == '0);
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_NEXT |=> pc == $past(pc) + 1'b1);
  assert_jump_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_JUMP |=> pc == {$past(page_q), $past(offset)});
  assert_page_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    page_we |=> page_q == $past(page_sel));
  assert_branch_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_BR && cond) |=> pc[PC_W-1 -: PG_W] == $past(pc[PC_W-1 -: PG_W]));
  assert_vector_R7: assert property (@(posedge clk) disable iff (!rst_n)
    op == OP_INT |=> pc == $past(vector));
  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op[2:1] == 2'b11 |=> $stable(pc));
endmodule

// File: tb/test_pc_stack_unit.sv
module test_pc_stack_unit;
  logic        clk = 0, rst_n = 0;
  logic [2:0]  op = 0;
  logic [10:0] offset = 0;
  logic        cond = 0;
  logic [12:0] vector = 0;
  logic        page_we = 0;
  logic [1:0]  page_sel = 0;
  logic [12:0] pc;

  pc_stack_unit i_pc_stack_unit (.clk, .rst_n, .op, .offset, .cond, .vector,
                                 .page_we, .page_sel, .pc);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [12:0] mpc = 0;
  logic [1:0]  mpage = 0;
  logic [12:0] q[$];

  task automatic check(input string tag, input logic [12:0] act, input logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: pc=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] o, input logic [10:0] ofs, input logic c,
                      input logic [12:0] vec, input logic we, input logic [1:0] ps,
                      input string tag);
    logic [12:0] nxt, v;
    op = o; offset = ofs; cond = c; vector = vec; page_we = we; page_sel = ps;
    case (o)
      3'd0: nxt = mpc + 13'd1;
      3'd1: nxt = {mpage, ofs};
      3'd2: begin q.push_back(mpc + 13'd1); void'(q.pop_front()); nxt = {mpage, ofs}; end
      3'd3: nxt = c ? {mpc[12:11], ofs} : mpc + 13'd1;
      3'd4: begin q.push_back(mpc); void'(q.pop_front()); nxt = vec; end
      3'd5: begin v = q.pop_back(); q.push_front(v); nxt = v; end
      default: nxt = mpc;
    endcase
    if (we) mpage = ps;
    @(negedge clk);
    check(tag, pc, nxt);
    mpc = nxt;
  endtask

  function automatic string tag_of(input logic [2:0] o);
    case (o)
      3'd0: return "R2 advance";
      3'd1: return "R3 jump";
      3'd2: return "R5 call";
      3'd3: return "R6 branch";
      3'd4: return "R7 interrupt";
      3'd5: return "R8 return";
      default: return "R11 hold";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: pc=%h expected=finish", pc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) q.push_back(13'd0);
    repeat (3) @(negedge clk);
    check("R1 reset", pc, 13'd0);
    rst_n = 1;
    step(3'd5, 0, 0, 0, 0, 0, "R10 pop empty after reset");
    step(3'd0, 0, 0, 0, 0, 0, "R2 advance");
    step(3'd0, 0, 0, 0, 0, 0, "R2 advance");
    step(3'd1, 11'h123, 0, 0, 1, 2'd2, "R4 jump uses old page");
    step(3'd1, 11'h045, 0, 0, 0, 0, "R4 jump uses new page");
    step(3'd1, 11'h7FF, 0, 0, 1, 2'd3, "R3 jump");
    step(3'd1, 11'h7FF, 0, 0, 0, 0, "R3 jump page 3");
    step(3'd0, 0, 0, 0, 0, 0, "R2 advance wrap to zero");
    step(3'd3, 11'h222, 1, 0, 0, 0, "R6 branch stays in page 0");
    step(3'd3, 11'h333, 0, 0, 0, 0, "R6 branch not taken");
    step(3'd2, 11'h010, 0, 0, 1, 2'd1, "R5 call");
    step(3'd3, 11'h055, 1, 0, 0, 0, "R6 branch in called page");
    step(3'd2, 11'h020, 0, 0, 0, 0, "R5 nested call");
    step(3'd4, 0, 0, 13'h0014, 0, 0, "R7 interrupt entry");
    step(3'd5, 0, 0, 0, 0, 0, "R8 return from interrupt");
    step(3'd5, 0, 0, 0, 0, 0, "R8 return");
    step(3'd5, 0, 0, 0, 0, 0, "R8 return outer");
    step(3'd6, 0, 0, 0, 0, 0, "R11 hold 110");
    step(3'd7, 0, 0, 0, 0, 0, "R11 hold 111");
    for (int i = 0; i < 10; i++)
      step(3'd2, 11'(i * 16 + 3), 0, 0, 1, 2'(i), "R9 deep call");
    for (int i = 0; i < 12; i++)
      step(3'd5, 0, 0, 0, 0, 0, i < 8 ? "R9 return after wrap" : "R10 over-pop");
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] o;
      o = 3'($urandom_range(0, 7));
      step(o, 11'($urandom), 1'($urandom), 13'($urandom), 1'($urandom), 2'($urandom),
           tag_of(o));
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule